// File: doc/BRIEF.md
# Mode-Switchable Floating-Point Register File

This block holds the floating-point register state of a processor: 32 entries of 64 bits, with one read port and one write port. Each access is either word-sized (32 bits) or double-sized (64 bits). A mode input picks how register indices map onto storage. In wide mode every index names its own 64-bit entry. In paired mode the file looks like 32 single-width registers, grouped two by two into 16 doubles. There, the odd member of a pair lives in the upper half of the even entry below it.

Reads are registered: the result and a valid strobe appear one clock after the request. A read that meets a write to the same storage in the same cycle returns the contents from before that write. A build parameter gives a single-precision-only variant. In that variant any odd register index is refused: a flag is raised, reads return zero, and writes leave storage untouched.

Top module: `fpr_bank`

## Requirements
- R1: A synchronous active-low reset clears every entry to zero and holds `rd_valid`, `rd_illegal` and `wr_illegal` low; reads issued after reset return zero.
- R2: With `wide_mode`=1, a double access (`*_dbl`=1) to index i reads or writes all 64 bits of entry i, and no other entry.
- R3: With `wide_mode`=1, a word access (`*_dbl`=0) to index i uses bits 31:0 of entry i. Every word read returns its value in `rd_data[31:0]` with `rd_data[63:32]` zero, and a word write takes its value from `wr_data[31:0]`.
- R4: With `wide_mode`=0, a double access to index i uses entry i with bit 0 cleared, so indices 2k and 2k+1 reach the same entry 2k.
- R5: With `wide_mode`=0, a word access to an even index i uses bits 31:0 of entry i.
- R6: With `wide_mode`=0, a word access to an odd index i uses bits 63:32 of entry i-1; entry i itself is not touched.
- R7: A word write changes only its own 32-bit half; the other half of the entry keeps its value.
- R8: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and `rd_data` then holds the value stored before any write in the request cycle (read-before-write).
- R9: When `SINGLE_ONLY`=1, an access with an odd index raises `rd_illegal` (or `wr_illegal`) in the following cycle, returns `rd_data`=0 and performs no write. When `SINGLE_ONLY`=0 both flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: independent 64-bit entries; 0: paired 32-bit view |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Read register index |
| rd_dbl | input | 1 | Read size: 1 double, 0 word |
| rd_valid | output | 1 | Read result valid (one cycle after `rd_en`) |
| rd_data | output | 64 | Read result; word reads zero-extended |
| rd_illegal | output | 1 | Read was refused (odd index, single-only build) |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_dbl | input | 1 | Write size: 1 double, 0 word |
| wr_data | input | 64 | Write data; word writes use bits 31:0 |
| wr_illegal | output | 1 | Write was refused (odd index, single-only build) |

## Verification
Index steering or half selection that goes wrong shows up at the read port one cycle after the first read that reaches the damaged entry. It appears as a value in the wrong half, a neighbour's data, or a half that was lost. Writes land silently, so the bench reads back every entry and half it has written, in both views. That includes cross-view reads: a paired write read back through the wide view reveals exactly which entry and half received it. A write that gets through in the single-only build is exposed by reading the legal even entry that the refused odd access would have reached.

// File: rtl/fpr_pkg.sv
// Shared types for the floating-point register file.
// Assumes a 64-bit entry made of two 32-bit halves, low half = lane 0.
package fpr_pkg;

    // Lane mask naming which halves of an entry an access touches.
    typedef enum logic [1:0] {
        HALF_NONE = 2'b00,
        HALF_LO   = 2'b01,
        HALF_HI   = 2'b10,
        HALF_BOTH = 2'b11
    } half_sel_e;

endpackage

// File: rtl/fpr_steer.sv
// Maps a register index, access size and view mode onto a physical entry
// and a half mask. Flags odd indices as illegal in the single-only build.
// Assumes IDX_W >= 2 so that a pair partner exists.
module fpr_steer
    import fpr_pkg::*;
#(
    parameter int IDX_W       = 5,
    parameter bit SINGLE_ONLY = 1'b0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             dbl,
    input  logic             wide,
    output logic [IDX_W-1:0] entry,
    output half_sel_e        half,
    output logic             illegal
);

    logic [IDX_W-1:0] even_idx;

    assign even_idx = {idx[IDX_W-1:1], 1'b0};

    // Purpose: choose entry and lanes for the current view and size.
    always_comb begin
        illegal = SINGLE_ONLY && idx[0];
        if (wide) begin
            entry = idx;
            half  = dbl ? HALF_BOTH : HALF_LO;
        end else if (dbl) begin
            entry = even_idx;
            half  = HALF_BOTH;
        end else if (idx[0]) begin
            entry = even_idx;
            half  = HALF_HI;
        end else begin
            entry = idx;
            half  = HALF_LO;
        end
    end

endmodule

// File: rtl/fpr_store.sv
// Storage array of DEPTH entries, each two HALF_W lanes, with per-lane
// write enables and an asynchronous (combinational) read of one entry.
// Assumes write data already aligned to the lanes it targets.
module fpr_store
    import fpr_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int HALF_W = 32,
    parameter int IDX_W  = 5,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_entry,
    input  half_sel_e         w_half,
    input  logic [WORD_W-1:0] w_data,
    input  logic [IDX_W-1:0]  r_entry,
    output logic [WORD_W-1:0] r_word
);

    logic [WORD_W-1:0] rows [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [HALF_W-1:0] lo_q;
        logic [HALF_W-1:0] hi_q;
        logic              hit;

        assign hit = we && (w_entry == IDX_W'(e));

        // Purpose: hold one entry, updating only the addressed lanes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (hit) begin
                if (w_half[0]) lo_q <= w_data[HALF_W-1:0];
                if (w_half[1]) hi_q <= w_data[WORD_W-1:HALF_W];
            end
        end

        assign rows[e] = {hi_q, lo_q};
    end

    assign r_word = rows[r_entry];

endmodule

// File: rtl/fpr_rd_pack.sv
// Formats a raw entry into the read-port value: full entry for doubles,
// the selected half zero-extended for words, zero when refused.
module fpr_rd_pack
    import fpr_pkg::*;
#(
    parameter int HALF_W = 32,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] word,
    input  half_sel_e         half,
    input  logic              illegal,
    output logic [WORD_W-1:0] data
);

    // Purpose: select and zero-extend the requested lanes.
    always_comb begin
        if (illegal) begin
            data = '0;
        end else begin
            unique case (half)
                HALF_HI:   data = {{HALF_W{1'b0}}, word[WORD_W-1:HALF_W]};
                HALF_LO:   data = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
                HALF_BOTH: data = word;
                default:   data = '0;
            endcase
        end
    end

endmodule

// File: rtl/fpr_bank.sv
// Floating-point register file with one registered read port and one
// write port, a wide view (independent 64-bit entries) and a paired view
// (odd word registers in the upper half of the even entry).
// Assumes the caller holds wide_mode steady across related accesses.
module fpr_bank
    import fpr_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int HALF_W      = 32,
    parameter bit SINGLE_ONLY = 1'b0,
    localparam int IDX_W      = $clog2(NUM_REGS),
    localparam int WORD_W     = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_dbl,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_illegal,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_dbl,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_illegal
);

    logic [IDX_W-1:0]  r_entry, w_entry;
    half_sel_e         r_half, w_half;
    logic              r_bad, w_bad;
    logic [WORD_W-1:0] r_word, r_fmt, w_aligned;

    fpr_steer #(.IDX_W(IDX_W), .SINGLE_ONLY(SINGLE_ONLY)) u_rd_steer (
        .idx(rd_idx), .dbl(rd_dbl), .wide(wide_mode),
        .entry(r_entry), .half(r_half), .illegal(r_bad)
    );

    fpr_steer #(.IDX_W(IDX_W), .SINGLE_ONLY(SINGLE_ONLY)) u_wr_steer (
        .idx(wr_idx), .dbl(wr_dbl), .wide(wide_mode),
        .entry(w_entry), .half(w_half), .illegal(w_bad)
    );

    // Word writes replicate the low word so either lane can take it.
    assign w_aligned = (w_half == HALF_BOTH) ? wr_data
                                             : {2{wr_data[HALF_W-1:0]}};

    fpr_store #(.DEPTH(NUM_REGS), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !w_bad), .w_entry(w_entry), .w_half(w_half),
        .w_data(w_aligned),
        .r_entry(r_entry), .r_word(r_word)
    );

    fpr_rd_pack #(.HALF_W(HALF_W)) u_pack (
        .word(r_word), .half(r_half), .illegal(r_bad), .data(r_fmt)
    );

    // Purpose: register read result and both refusal flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_illegal <= 1'b0;
            rd_data    <= '0;
            wr_illegal <= 1'b0;
        end else begin
            rd_valid   <= rd_en;
            rd_illegal <= rd_en && r_bad;
            wr_illegal <= wr_en && w_bad;
            if (rd_en) rd_data <= r_fmt;
        end
    end

endmodule

// File: rtl/fpr_bank_chk.sv
// Port-level timing and flag properties of fpr_bank, bound to every instance.
module fpr_bank_chk #(
    parameter int IDX_W       = 5,
    parameter int HALF_W      = 32,
    parameter bit SINGLE_ONLY = 1'b0,
    localparam int WORD_W     = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rd_dbl,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_illegal,
    input logic              wr_illegal
);

    // R1: first cycle out of reset is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rd_valid && !rd_illegal && !wr_illegal));

    // R8: valid strobe follows a request by exactly one cycle.
    assert_valid_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R3: word reads come back zero-extended.
    assert_word_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_dbl) |=> (rd_data[WORD_W-1:HALF_W] == '0));

    // R9: refusal flags follow odd indices only in the single-only build.
    assert_rd_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_illegal == (SINGLE_ONLY && $past(rd_idx[0]))));
    assert_wr_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_illegal == (SINGLE_ONLY && $past(wr_idx[0]))));
    assert_wr_flag_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_illegal);
    assert_refused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_valid && rd_data == '0));

endmodule

bind fpr_bank fpr_bank_chk #(
    .IDX_W(IDX_W), .HALF_W(HALF_W), .SINGLE_ONLY(SINGLE_ONLY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_dbl(rd_dbl), .wr_en(wr_en), .wr_idx(wr_idx),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_illegal(rd_illegal),
    .wr_illegal(wr_illegal)
);

// File: tb/tb_fpr_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected results, monitors compare
// them when rd_valid appears. A reference array models the full build.
module tb_fpr_bank;

    typedef struct {
        logic [63:0] data;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide = 1'b1;
    logic        rd_en = 1'b0, so_rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic        rd_dbl = 1'b0;
    logic        wr_en = 1'b0, so_wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_dbl = 1'b0;
    logic [63:0] wr_data = '0;

    logic        rd_valid, rd_illegal, wr_illegal;
    logic [63:0] rd_data;
    logic        so_rd_valid, so_rd_illegal, so_wr_illegal;
    logic [63:0] so_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q_main[$];
    exp_t q_so[$];
    logic [63:0] model [32];

    always #2.5 clk = ~clk;

    fpr_bank dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_dbl(rd_dbl),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_illegal(rd_illegal),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_dbl(wr_dbl), .wr_data(wr_data),
        .wr_illegal(wr_illegal)
    );

    fpr_bank #(.SINGLE_ONLY(1'b1)) dut_so (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide),
        .rd_en(so_rd_en), .rd_idx(rd_idx), .rd_dbl(rd_dbl),
        .rd_valid(so_rd_valid), .rd_data(so_rd_data), .rd_illegal(so_rd_illegal),
        .wr_en(so_wr_en), .wr_idx(wr_idx), .wr_dbl(wr_dbl), .wr_data(wr_data),
        .wr_illegal(so_wr_illegal)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected read value from the requirements (R2-R6), model of full build.
    function automatic logic [63:0] mexp(bit m, logic [4:0] i, bit d);
        logic [4:0] ev;
        ev = {i[4:1], 1'b0};
        if (m) return d ? model[i] : {32'h0, model[i][31:0]};
        if (d) return model[ev];
        if (i[0]) return {32'h0, model[ev][63:32]};
        return {32'h0, model[i][31:0]};
    endfunction

    function automatic void mwrite(bit m, logic [4:0] i, bit d, logic [63:0] v);
        logic [4:0] ev;
        ev = {i[4:1], 1'b0};
        if (m && d)      model[i] = v;
        else if (m)      model[i][31:0] = v[31:0];
        else if (d)      model[ev] = v;
        else if (i[0])   model[ev][63:32] = v[31:0];
        else             model[i][31:0] = v[31:0];
    endfunction

    // Write one access; checks the refusal flag of the addressed instance.
    task automatic wr(bit so, bit m, logic [4:0] i, bit d, logic [63:0] v,
                      bit exp_ill, string tag);
        @(negedge clk);
        wide = m; wr_idx = i; wr_dbl = d; wr_data = v;
        if (so) so_wr_en = 1'b1; else wr_en = 1'b1;
        if (!so) mwrite(m, i, d, v);
        @(negedge clk);
        wr_en = 1'b0; so_wr_en = 1'b0;
        if (so) check(so_wr_illegal == exp_ill, tag, 65'(so_wr_illegal), 65'(exp_ill));
        else    check(wr_illegal == exp_ill, tag, 65'(wr_illegal), 65'(exp_ill));
    endtask

    // Issue one read and queue its expected result.
    task automatic rd(bit so, bit m, logic [4:0] i, bit d,
                      logic [63:0] exp, bit ill, string tag);
        exp_t it;
        @(negedge clk);
        wide = m; rd_idx = i; rd_dbl = d;
        it.data = exp; it.ill = ill; it.tag = tag;
        if (so) begin so_rd_en = 1'b1; q_so.push_back(it); end
        else    begin rd_en = 1'b1;    q_main.push_back(it); end
        @(negedge clk);
        rd_en = 1'b0; so_rd_en = 1'b0;
    endtask

    // Read and write the same half in one cycle on the main instance.
    task automatic rw_same(bit m, logic [4:0] i, bit d, logic [63:0] v, string tag);
        exp_t it;
        @(negedge clk);
        wide = m; rd_idx = i; rd_dbl = d; wr_idx = i; wr_dbl = d; wr_data = v;
        it.data = mexp(m, i, d); it.ill = 1'b0; it.tag = tag;
        q_main.push_back(it);
        mwrite(m, i, d, v);
        rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: compare main-instance results against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_main.size() == 0) begin
                check(1'b0, "R8 unexpected rd_valid", 65'(rd_data), 65'(0));
            end else begin
                exp_t it;
                it = q_main.pop_front();
                check({rd_illegal, rd_data} == {it.ill, it.data}, it.tag,
                      {rd_illegal, rd_data}, {it.ill, it.data});
            end
        end
    end

    // Monitor: compare single-only instance results.
    always @(negedge clk) begin
        if (rst_n && so_rd_valid) begin
            if (q_so.size() == 0) begin
                check(1'b0, "R8 unexpected so rd_valid", 65'(so_rd_data), 65'(0));
            end else begin
                exp_t it;
                it = q_so.pop_front();
                check({so_rd_illegal, so_rd_data} == {it.ill, it.data}, it.tag,
                      {so_rd_illegal, so_rd_data}, {it.ill, it.data});
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) model[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(!rd_valid && !rd_illegal && !wr_illegal, "R1 quiet after reset",
              65'({rd_valid, rd_illegal, wr_illegal}), 65'(0));

        // R1: cleared entries
        rd(0, 1, 5'd0,  1, 64'h0, 0, "R1 entry 0 cleared");
        rd(0, 1, 5'd31, 1, 64'h0, 0, "R1 entry 31 cleared");
        rd(1, 0, 5'd2,  1, 64'h0, 0, "R1 single-only entry 2 cleared");

        // R2: wide doubles are independent
        wr(0, 1, 5'd5, 1, 64'hA5A5_0001_C3C3_0002, 0, "R9 no flag in full build");
        rd(0, 1, 5'd5, 1, mexp(1, 5'd5, 1), 0, "R2 wide double read");
        wr(0, 1, 5'd4, 1, 64'h0123_4567_89AB_CDEF, 0, "R9 no flag in full build");
        rd(0, 1, 5'd5, 1, mexp(1, 5'd5, 1), 0, "R2 neighbour untouched");
        rd(0, 1, 5'd4, 1, mexp(1, 5'd4, 1), 0, "R2 second entry");

        // R3 / R7: wide word access on low half
        wr(0, 1, 5'd7, 1, 64'hDEAD_BEEF_0BAD_F00D, 0, "R9 no flag in full build");
        wr(0, 1, 5'd7, 0, 64'hFFFF_FFFF_1111_2222, 0, "R9 no flag in full build");
        rd(0, 1, 5'd7, 0, mexp(1, 5'd7, 0), 0, "R3 wide word low half");
        rd(0, 1, 5'd7, 1, mexp(1, 5'd7, 1), 0, "R7 upper half kept");

        // R4: paired double lands on even entry
        wr(0, 0, 5'd9, 1, 64'h5555_6666_7777_8888, 0, "R9 no flag in full build");
        rd(0, 1, 5'd8, 1, mexp(1, 5'd8, 1), 0, "R4 paired double in entry 8");
        rd(0, 1, 5'd9, 1, mexp(1, 5'd9, 1), 0, "R4 entry 9 untouched");
        rd(0, 0, 5'd9, 1, mexp(0, 5'd9, 1), 0, "R4 odd index aliases even");

        // R5 / R6: paired words
        wr(0, 0, 5'd10, 0, 64'h0000_0000_AAAA_0010, 0, "R9 no flag in full build");
        wr(0, 0, 5'd11, 0, 64'h0000_0000_BBBB_0011, 0, "R9 odd word no flag");
        rd(0, 0, 5'd10, 1, mexp(0, 5'd10, 1), 0, "R6 pair forms one double");
        rd(0, 0, 5'd11, 0, mexp(0, 5'd11, 0), 0, "R6 odd word from upper half");
        rd(0, 0, 5'd10, 0, mexp(0, 5'd10, 0), 0, "R5 even word from lower half");
        rd(0, 1, 5'd11, 1, mexp(1, 5'd11, 1), 0, "R6 entry 11 untouched");

        // R7: paired upper-half write keeps lower half
        wr(0, 0, 5'd5, 0, 64'h0000_0000_CAFE_0005, 0, "R9 no flag in full build");
        rd(0, 1, 5'd4, 1, mexp(1, 5'd4, 1), 0, "R7 lower half kept");

        // R8: read-before-write on the same half
        rw_same(0, 5'd11, 0, 64'h0000_0000_EEEE_0011, "R8 same-cycle read sees old");
        rd(0, 0, 5'd11, 0, mexp(0, 5'd11, 0), 0, "R8 new value after write");
        rw_same(1, 5'd4, 1, 64'h1357_9BDF_2468_ACE0, "R8 same-cycle double old");
        rd(0, 1, 5'd4, 1, mexp(1, 5'd4, 1), 0, "R8 double new value");

        // R9: single-only build refuses odd indices
        wr(1, 0, 5'd3, 0, 64'h0000_0000_7777_0003, 1, "R9 odd write flagged");
        rd(1, 0, 5'd2, 1, 64'h0, 0, "R9 refused write left entry 2");
        rd(1, 0, 5'd3, 0, 64'h0, 1, "R9 odd read flagged zero");
        wr(1, 1, 5'd1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R9 odd wide write flagged");
        rd(1, 1, 5'd0, 1, 64'h0, 0, "R9 entry 0 untouched");
        wr(1, 0, 5'd2, 0, 64'h0000_0000_4242_0002, 0, "R9 even write legal");
        rd(1, 0, 5'd2, 1, 64'h0000_0000_4242_0002, 0, "R5 single-only even word");

        repeat (3) @(negedge clk);
        check(q_main.size() == 0 && q_so.size() == 0, "R8 all reads answered",
              65'(q_main.size() + q_so.size()), 65'(0));
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule